// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

This block measures how fast a main clock runs by counting its cycles across a fixed window of periods of a slow reference clock. The slow reference is asynchronous to the main clock. It is brought into the main-clock domain through a two-flop synchronizer, and its falling edges are detected there. All logic runs on the main clock.

A measurement starts when a start pulse arrives, or when the oscillator-selection input changes value. The meter first waits for a reference falling edge. From that edge it counts main-clock cycles until 16 further falling edges have been seen. It then freezes the count and raises a sticky ready flag. A host reads the count and the flag as a simple read port. The count is 16 bits wide and saturates at all-ones, so a main clock that is too fast reads as full scale rather than as a wrapped value.

Top module: `freq_meter`

## Requirements
- R1: After reset, `count_o` is 0 and `ready_o` is 0. Both stay there, with no counting, until the first restart, whatever `slow_clk_i` does.
- R2: A restart clears `count_o` and `ready_o` to 0 at the next rising edge of `clk_i`. A restart is `start_i` high at a rising edge, or `osc_sel_i` differing from its value at the previous edge. The meter then waits for a reference falling edge.
- R3: The first detected falling edge after a restart opens the window. From the next edge of `clk_i` onward, `count_o` rises by exactly one per `clk_i` cycle. When the reference period is a whole number N of main cycles, the final count is 16·N, which is within one of the ideal value.
- R4: `ready_o` rises at the same `clk_i` edge as the 16th detected falling edge after the window-opening edge. That edge performs the last increment.
- R5: While `ready_o` is 1 and no restart occurs, `ready_o` stays 1 and `count_o` keeps its value, whatever reference edges arrive.
- R6: `count_o` never wraps. It stops at 16'hFFFF until the next restart.
- R7: A falling edge of `slow_clk_i` is first seen low at `clk_i` edge k, having been high at edge k-1. That edge acts on the state at edge k+2.
- R8: A restart takes priority over a reference falling edge detected at the same edge. That falling edge neither opens the window nor counts.
- R9: An `osc_sel_i` that holds its value causes no restart, so a finished result stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock being measured |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | Slow reference clock, asynchronous to `clk_i` |
| start_i | input | 1 | Start pulse, synchronous to `clk_i` |
| osc_sel_i | input | SEL_W | Oscillator selection; any change restarts the measurement |
| count_o | output | CNT_W | Main-clock cycles counted over the window, saturating |
| ready_o | output | 1 | Sticky flag: the window has ended and the count is frozen |

## Verification
The assertions take for granted that `start_i` and `osc_sel_i` are synchronous to `clk_i`. They also assume the reference stays low and high for at least two main-clock cycles each, so that the synchronizer never merges or drops an edge. The stimulus derives the reference from the main clock and changes it only on falling edges of `clk_i`, with whole-number ratios of at least 7 main cycles per reference period. It also drives start and selection inputs only on falling edges. That keeps every sampled value unambiguous, which lets a behavioural model predict the count exactly on every cycle. Ratios of 7, 50 and 333 cover normal results, and 4200 drives the count into saturation.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_RUN  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/fm_sync_fall.sv
module fm_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~chain_q[STAGES-1];

  // one detected edge lasts a single cycle
  p_fall_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/fm_window.sv
module fm_window
  import freq_meter_pkg::*;
#(
  parameter int unsigned EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic fall_i,
  output logic run_o,
  output logic done_o
);
  localparam int unsigned EW = (EDGES > 1) ? $clog2(EDGES) : 1;
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  phase_e        state_q;
  logic [EW-1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      edges_q <= '0;
    end else if (restart_i) begin
      state_q <= PH_ARM;
      edges_q <= '0;
    end else begin
      unique case (state_q)
        PH_ARM: if (fall_i) begin
          state_q <= PH_RUN;
          edges_q <= '0;
        end
        PH_RUN: if (fall_i) begin
          if (edges_q == LAST) state_q <= PH_DONE;
          else                 edges_q <= edges_q + EW'(1);
        end
        default: ;
      endcase
    end
  end

  assign run_o  = (state_q == PH_RUN);
  assign done_o = (state_q == PH_DONE);

  p_restart_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == PH_ARM));
  p_done_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(run_o) && $past(fall_i)));
  p_restart_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && fall_i) |=> !run_o);
endmodule

// File: rtl/fm_sat_counter.sv
module fm_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAXV) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAXV && !clear_i) |=> (cnt_o == MAXV));
  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clear_i && cnt_o != MAXV) |=> (cnt_o == $past(cnt_o) + W'(1)));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned WINDOW      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_clk_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] osc_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o
);
  logic [SEL_W-1:0] sel_q;
  logic             restart;
  logic             fall;
  logic             run;
  logic             done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= osc_sel_i;
  end

  assign restart = start_i | (osc_sel_i != sel_q);

  fm_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (slow_clk_i),
    .fall_o  (fall)
  );

  fm_window #(.EDGES(WINDOW)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .fall_i    (fall),
    .run_o     (run),
    .done_o    (done)
  );

  fm_sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .inc_i   (run),
    .cnt_o   (count_o)
  );

  assign ready_o = done;

  p_restart_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (count_o == '0 && !ready_o));
  p_ready_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !restart) |=> ready_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !restart) |=> $stable(count_o));
  p_same_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i && $stable(osc_sel_i)) |=> ready_o);
endmodule

// File: tb/freq_meter_tb.sv
`timescale 1ns/1ps
module freq_meter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] count;
  logic        ready;

  int n_cmp = 0;
  int n_bad = 0;
  int ratio = 0;
  int ph = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  freq_meter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow), .start_i(start),
    .osc_sel_i(sel), .count_o(count), .ready_o(ready)
  );

  // reference derived from the main clock, changes only on falling edges
  always @(negedge clk) begin
    if (ratio > 0) begin
      slow = (ph < ratio / 2);
      ph = (ph + 1) % ratio;
    end
  end

  // behavioural reference model
  int  m_phase;  // 0 idle, 1 arm, 2 run, 3 done
  int  m_cnt;
  int  m_edges;
  bit  m_ready;
  logic [1:0] m_sel;
  bit  h1, h2, h3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_edges = 0; m_ready = 0; m_sel = 2'd0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit f;
      bit rs;
      f  = h3 && !h2;   // R7: edge sampled two clocks earlier
      rs = start || (sel != m_sel);
      m_sel = sel;
      h3 = h2; h2 = h1; h1 = slow;
      if (rs) begin
        m_phase = 1; m_cnt = 0; m_edges = 0; m_ready = 0;
      end else if (m_phase == 1) begin
        if (f) begin m_phase = 2; m_edges = 0; end
      end else if (m_phase == 2) begin
        if (m_cnt < 65535) m_cnt++;
        if (f) begin
          if (m_edges == 15) begin m_phase = 3; m_ready = 1; end
          else m_edges++;
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(count == 16'(m_cnt), "R3 R7 R8 count vs model", count, m_cnt);
      check(ready == m_ready, "R4 R5 ready vs model", ready, m_ready);
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic set_ratio(int r);
    @(negedge clk);
    ratio = r; ph = 0;
  endtask

  task automatic wait_ready(int lim);
    for (int i = 0; i < lim && !ready; i++) @(negedge clk);
  endtask

  task automatic measure(int r);
    int exp;
    set_ratio(r);
    pulse_start();
    wait_ready(17 * r + 40);
    @(negedge clk);
    exp = (16 * r > 65535) ? 65535 : 16 * r;
    check(ready == 1'b1, "R4 ready after window", ready, 1);
    if (16 * r > 65535)
      check(count == 16'hFFFF, "R6 saturated count", count, 65535);
    else
      check((count >= exp - 1) && (count <= exp + 1), "R3 count within one of ideal", count, exp);
  endtask

  initial begin
    int held;
    repeat (4) @(negedge clk);
    check(count == 0 && ready == 0, "R1 reset state", {15'd0, ready} + count, 0);
    rst_n = 1'b1;
    set_ratio(7);
    repeat (200) @(negedge clk);
    check(count == 0 && ready == 0, "R1 idle without restart", {15'd0, ready} + count, 0);

    measure(7);
    measure(50);
    held = count;
    repeat (150) @(negedge clk);
    check(ready == 1'b1, "R5 ready sticky", ready, 1);
    check(count == 16'(held), "R5 count held", count, held);

    repeat (20) @(negedge clk);
    check(ready == 1'b1 && count == 16'(held), "R9 same selection no restart", count, held);
    @(negedge clk) sel = 2'd2;
    @(negedge clk);
    check(count == 0 && ready == 0, "R9 selection change restarts", count, 0);
    check(ready == 1'b0, "R2 restart clears ready", ready, 0);
    wait_ready(17 * 50 + 40);
    @(negedge clk);
    check(ready == 1'b1 && count == 16'd800, "R9 R3 measurement after reselect", count, 800);

    measure(333);
    pulse_start();
    check(count == 0 && ready == 0, "R2 start clears result", count, 0);

    // R8: restart coincident with a detected falling edge
    while (!(h3 && !h2)) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(count == 0 && ready == 0, "R8 restart beats edge", count, 0);
    repeat (20) @(negedge clk);
    check(count == 0, "R8 edge did not open window", count, 0);
    wait_ready(17 * 333 + 40);
    @(negedge clk);
    check(count == 16'd5328, "R8 R3 window after coincident restart", count, 5328);

    measure(4200);
    repeat (300) @(negedge clk);
    check(count == 16'hFFFF && ready, "R6 saturation held", count, 65535);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule